// File: doc/BRIEF.md
# Power-Switch Fault and Sleep Supervisor

This block is the digital controller of a PWM-driven high-side power switch. A single input line carries the PWM command from the host. The same line wakes the block from its low-power state and carries fault diagnostics back to the host. The supervisor passes the input through a synchronizer. It qualifies wake-up pulses, holds the output off during a power-on interval and then lets the gate enable follow the input. It latches over-current, over-temperature and over-power events. Each of these turns the switch off at once and tells the gate driver to skip its slope-controlled turn-off.

While a fault is latched, the block produces a square wave that pulls the shared input line low. Its frequency tells the host which fault occurred. A latched fault can be cleared only by a long low period on the input: the block goes to sleep, and after a further clear interval spent asleep the faults are erased. Undervoltage is handled separately. It blocks the output only while the comparator flag is active and is never latched. All durations are counts of the system clock, set by parameters.

Top module: `hss_supervisor`

## Requirements
- R1: In the run state, with no fault and no undervoltage, `gate_en` equals the input level delayed by two clock edges, the depth of the synchronizer.
- R2: After `SLEEP_CYC` consecutive low input samples, the block enters sleep, and 39 low samples with `SLEEP_CYC`=40 do not. A wake-up from sleep is accepted only after `WAKE_MIN_CYC` consecutive high samples. A shorter high pulse returns the block to sleep with no effect.
- R3: After a wake-up is accepted, `gate_en` stays low for `POR_CYC` further cycles. When the input rises while the block is asleep, `gate_en` first goes high 2+`WAKE_MIN_CYC`+`POR_CYC` edges later.
- R4: A high level on `oc_req`, `ot_req` or `op_req` at a clock edge latches that fault. After that same edge `gate_en` is low and `fast_off` is high, and both stay so after the request drops.
- R5: While a fault is latched and the block is awake, `diag_pull` is a square wave with a period of 2×`DIAG_OT_HALF` cycles if over-temperature is latched. Otherwise the period is 2×`DIAG_OC_HALF` cycles, which is also used for over-power alone. Over-temperature takes priority when it is latched together with over-current.
- R6: Latched faults clear only after the block has stayed asleep for `CLR_CYC` cycles. A wake-up before that keeps the faults, and a low period shorter than the sleep timeout never clears them.
- R7: While `uv_flag` is high, `gate_en` is low in the same cycle. `fast_off` does not rise, and `gate_en` follows the input again as soon as `uv_flag` drops.
- R8: After reset the block is asleep, with `gate_en`, `fast_off` and `diag_pull` low.
- R9: `diag_pull` stays low when no fault is latched, and also while the block is asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | Asynchronous PWM command / wake line level |
| uv_flag | input | 1 | Undervoltage comparator output, high = supply too low |
| oc_req | input | 1 | Over-current fault request |
| ot_req | input | 1 | Over-temperature fault request |
| op_req | input | 1 | Over-power fault request |
| gate_en | output | 1 | Enable for the power stage gate driver |
| fast_off | output | 1 | High while a fault is latched; driver skips slope-controlled turn-off |
| diag_pull | output | 1 | Drives the input line low when high; fault-coded square wave |

## Verification
The bench builds the block with a 40-cycle sleep timeout, a 4-cycle wake qualifier, an 8-cycle power-on interval, a 20-cycle clear interval, and diagnostic half-periods of 3 and 6 cycles. These short values make it practical to run full sleep, clear and wake sequences, one after another. They also allow exact edge counts on both sides of the sleep threshold. The bench measures diagnostic periods directly and can tell a rejected wake pulse from an accepted one by the power-on latency that follows.

// File: rtl/hss_pkg.sv
// Shared types for the power-switch supervisor.
// Assumes: fault vector bit order is fixed as listed below.
package hss_pkg;

    // Power state of the supervisor.
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_WAKE  = 2'd1,
        ST_POR   = 2'd2,
        ST_RUN   = 2'd3
    } pwr_st_e;

    localparam int NFLT   = 3;
    localparam int FLT_OC = 0;
    localparam int FLT_OT = 1;
    localparam int FLT_OP = 2;

endpackage

// File: rtl/hss_in_sync.sv
// Multi-flop synchronizer for the asynchronous PWM/wake line.
// Assumes: STAGES >= 2; output lags the input by STAGES edges.
module hss_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], din};
    end

    assign dout = sh[STAGES-1];
endmodule

// File: rtl/hss_fault_latch.sv
// Sticky fault flags, one per fault source.
// Assumes: a set request wins over a clear request in the same cycle.
module hss_fault_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_req,
    input  logic         clr,
    output logic [N-1:0] flt
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold one fault flag until a clear pulse arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)          flt[i] <= 1'b0;
            else if (set_req[i]) flt[i] <= 1'b1;
            else if (clr)        flt[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/hss_diag_gen.sv
// Fault-coded square wave that pulls the shared input line low.
// Assumes: half periods >= 2; the wave restarts low whenever it is enabled.
module hss_diag_gen #(
    parameter int OT_HALF = 96154,
    parameter int OC_HALF = 357143
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic use_ot,
    output logic pull
);
    localparam int HMAX = (OT_HALF > OC_HALF) ? OT_HALF : OC_HALF;
    localparam int HW   = $clog2(HMAX);

    logic [HW-1:0] cnt;
    logic [HW-1:0] lim;

    // Pick the half-period for the fault class being reported.
    always_comb lim = use_ot ? HW'(OT_HALF - 1) : HW'(OC_HALF - 1);

    // Count half-periods and toggle the wave at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt  <= '0;
            pull <= 1'b0;
        end else if (cnt >= lim) begin
            cnt  <= '0;
            pull <= ~pull;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    AST_DIAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pull); // R9
    AST_DIAG_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> cnt < HW'(HMAX)); // R5
endmodule

// File: rtl/hss_supervisor.sv
// Sleep, wake, power-on and fault supervisor for a PWM-driven high-side switch.
// Assumes: pwm_in is asynchronous; fault requests and uv_flag are synchronous
// to clk; WAKE_MIN_CYC, POR_CYC, CLR_CYC, SLEEP_CYC >= 2. Defaults fit 50 MHz.
module hss_supervisor #(
    parameter int SYNC_STAGES  = 2,
    parameter int SLEEP_CYC    = 1500000,
    parameter int WAKE_MIN_CYC = 100,
    parameter int POR_CYC      = 400,
    parameter int CLR_CYC      = 2500,
    parameter int DIAG_OT_HALF = 96154,
    parameter int DIAG_OC_HALF = 357143
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic uv_flag,
    input  logic oc_req,
    input  logic ot_req,
    input  logic op_req,
    output logic gate_en,
    output logic fast_off,
    output logic diag_pull
);
    import hss_pkg::*;

    localparam int CMAX0 = (CLR_CYC > POR_CYC) ? CLR_CYC : POR_CYC;
    localparam int CMAX  = (CMAX0 > WAKE_MIN_CYC) ? CMAX0 : WAKE_MIN_CYC;
    localparam int CW    = $clog2(CMAX + 1);
    localparam int LW    = $clog2(SLEEP_CYC + 1);

    pwr_st_e          st;
    logic [CW-1:0]    cnt;
    logic [LW-1:0]    lowcnt;
    logic             s_in;
    logic             clr_pulse;
    logic             low_done;
    logic [NFLT-1:0]  flt;
    logic [NFLT-1:0]  req_vec;

    hss_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pwm_in),
        .dout (s_in)
    );

    // Gather fault requests into the package bit order.
    always_comb begin
        req_vec         = '0;
        req_vec[FLT_OC] = oc_req;
        req_vec[FLT_OT] = ot_req;
        req_vec[FLT_OP] = op_req;
    end

    hss_fault_latch #(.N(NFLT)) u_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(req_vec),
        .clr    (clr_pulse),
        .flt    (flt)
    );

    // Clear fires once, when the sleep dwell reaches the clear interval.
    always_comb clr_pulse = (st == ST_SLEEP) && !s_in && (cnt == CW'(CLR_CYC - 1));

    // Last low sample of the sleep timeout window.
    always_comb low_done = !s_in && (lowcnt == LW'(SLEEP_CYC - 1));

    // Power state machine with its shared interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_SLEEP;
            cnt    <= '0;
            lowcnt <= '0;
        end else begin
            case (st)
                ST_SLEEP: begin
                    lowcnt <= '0;
                    if (s_in) begin
                        st  <= ST_WAKE;
                        cnt <= CW'(1);
                    end else if (cnt != CW'(CLR_CYC)) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (!s_in) begin
                        st  <= ST_SLEEP;
                        cnt <= '0;
                    end else if (cnt == CW'(WAKE_MIN_CYC - 1)) begin
                        st  <= ST_POR;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (low_done) begin
                        st     <= ST_SLEEP;
                        cnt    <= '0;
                        lowcnt <= '0;
                    end else begin
                        lowcnt <= s_in ? '0 : lowcnt + 1'b1;
                        if (st == ST_POR) begin
                            if (cnt == CW'(POR_CYC - 1)) begin
                                st  <= ST_RUN;
                                cnt <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // Output enable: run state, command high, no fault, supply good.
    always_comb gate_en = (st == ST_RUN) && s_in && !(|flt) && !uv_flag;

    // Any latched fault requests the hard turn-off.
    always_comb fast_off = |flt;

    hss_diag_gen #(.OT_HALF(DIAG_OT_HALF), .OC_HALF(DIAG_OC_HALF)) u_diag (
        .clk   (clk),
        .rst_n (rst_n),
        .active((|flt) && (st != ST_SLEEP)),
        .use_ot(flt[FLT_OT]),
        .pull  (diag_pull)
    );

    AST_GATE_RUN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_RUN) |-> !gate_en); // R3
    AST_FAULT_BLOCKS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        fast_off |-> !gate_en); // R4
    AST_UV_BLOCKS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |-> !gate_en); // R7
    AST_CLEAR_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_off) |-> $past(st) == ST_SLEEP); // R6
    AST_POR_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POR && $past(st) != ST_POR) |-> $past(st) == ST_WAKE); // R2
    AST_POR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POR) |-> cnt < CW'(POR_CYC)); // R3
endmodule

// File: tb/sim_hss_supervisor.sv
// Self-checking bench: vector table walk, then directed corner cases.
module sim_hss_supervisor;
    localparam int SLEEP = 40;
    localparam int WAKEM = 4;
    localparam int POR   = 8;
    localparam int CLR   = 20;
    localparam int OTH   = 3;
    localparam int OCH   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_in = 1'b0, uv_flag = 1'b0, oc_req = 1'b0, ot_req = 1'b0, op_req = 1'b0;
    logic gate_en, fast_off, diag_pull;
    int   errs = 0;
    int   checks = 0;

    always #4 clk = ~clk;

    hss_supervisor #(
        .SYNC_STAGES(2), .SLEEP_CYC(SLEEP), .WAKE_MIN_CYC(WAKEM), .POR_CYC(POR),
        .CLR_CYC(CLR), .DIAG_OT_HALF(OTH), .DIAG_OC_HALF(OCH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .uv_flag(uv_flag),
        .oc_req(oc_req), .ot_req(ot_req), .op_req(op_req),
        .gate_en(gate_en), .fast_off(fast_off), .diag_pull(diag_pull)
    );

    typedef struct packed {
        logic [4:0] ins;   // pwm, uv, oc, ot, op
        logic [7:0] hold;
        logic       g;
        logic       f;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{5'b10000, 8'd20, 1'b1, 1'b0, 4'd3},  // R3 wake and power-on, then run
        '{5'b00000, 8'd5,  1'b0, 1'b0, 4'd1},  // R1 follow low
        '{5'b10000, 8'd5,  1'b1, 1'b0, 4'd1},  // R1 follow high
        '{5'b11000, 8'd3,  1'b0, 1'b0, 4'd7},  // R7 undervoltage blocks
        '{5'b10000, 8'd3,  1'b1, 1'b0, 4'd7},  // R7 recovers, not latched
        '{5'b10100, 8'd1,  1'b0, 1'b1, 4'd4},  // R4 over-current latches
        '{5'b10000, 8'd10, 1'b0, 1'b1, 4'd4},  // R4 stays latched
        '{5'b00000, 8'd30, 1'b0, 1'b1, 4'd6},  // R6 short low keeps fault
        '{5'b10000, 8'd5,  1'b0, 1'b1, 4'd6},  // R6 still latched
        '{5'b00000, 8'd50, 1'b0, 1'b1, 4'd6},  // R6 sleep too short to clear
        '{5'b10000, 8'd20, 1'b0, 1'b1, 4'd6},  // R6 early wake keeps fault
        '{5'b00000, 8'd70, 1'b0, 1'b0, 4'd6},  // R6 full dwell clears
        '{5'b10000, 8'd20, 1'b1, 1'b0, 4'd6},  // R6 runs again after clear
        '{5'b10010, 8'd1,  1'b0, 1'b1, 4'd4},  // R4 over-temperature latches
        '{5'b10000, 8'd3,  1'b0, 1'b1, 4'd4}   // R4 held after request drops
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply inputs at a falling edge and wait n rising edges.
    task automatic apply(input logic [4:0] v, input int n);
        {pwm_in, uv_flag, oc_req, ot_req, op_req} = v;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Raise the input and count edges until gate_en goes high.
    task automatic rise_latency(output int n);
        pwm_in = 1'b1;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!gate_en && n < 100);
    endtask

    // Measure rising-edge to rising-edge period of diag_pull.
    task automatic diag_period(output int p);
        logic prev;
        int   k;
        prev = diag_pull;
        k = 0;
        while (!(!prev && diag_pull) && k < 200) begin
            prev = diag_pull; apply({pwm_in, uv_flag, 3'b000}, 1); k++;
        end
        p = 0;
        prev = diag_pull;
        while (!(!prev && diag_pull) && p < 200) begin
            prev = diag_pull; apply({pwm_in, uv_flag, 3'b000}, 1); p++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int lat;
        int per;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 gate_en after reset", int'(gate_en), 0);
        chk("R8 fast_off after reset", int'(fast_off), 0);
        chk("R8 diag_pull after reset", int'(diag_pull), 0);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].ins, int'(TBL[i].hold));
            checks++;
            if (gate_en !== TBL[i].g || fast_off !== TBL[i].f) begin
                errs++;
                $display("FAIL R%0d row %0d actual gate=%b fast=%b expected gate=%b fast=%b",
                         TBL[i].req, i, gate_en, fast_off, TBL[i].g, TBL[i].f);
            end
        end

        // R5 over-temperature period, then priority over over-current.
        diag_period(per);
        chk("R5 over-temperature period", per, 2 * OTH);
        apply(5'b10100, 1);
        apply(5'b10000, 1);
        diag_period(per);
        chk("R5 over-temperature priority", per, 2 * OTH);

        // R9 no pulling while asleep, then R6 clear after dwell.
        apply(5'b00000, 45);
        chk("R9 diag_pull asleep", int'(diag_pull), 0);
        chk("R6 fault kept at sleep entry", int'(fast_off), 1);
        apply(5'b00000, 30);
        chk("R6 fault cleared", int'(fast_off), 0);

        // R4 and R5: over-power uses the over-current period.
        apply(5'b10000, 20);
        chk("R1 running before op fault", int'(gate_en), 1);
        apply(5'b10001, 1);
        chk("R4 op fault fast_off", int'(fast_off), 1);
        apply(5'b10000, 1);
        diag_period(per);
        chk("R5 over-power period", per, 2 * OCH);

        // R2 short wake pulse rejected; R3 full latency afterwards.
        apply(5'b00000, 75);
        chk("R9 diag_pull with no fault", int'(diag_pull), 0);
        apply(5'b10000, WAKEM - 1);
        apply(5'b00000, 4);
        rise_latency(lat);
        chk("R2 R3 latency after rejected pulse", lat, 2 + WAKEM + POR);

        // R2 sleep threshold on both sides.
        apply(5'b00000, SLEEP - 1);
        rise_latency(lat);
        chk("R2 no sleep one sample short", lat, 2);
        apply(5'b00000, SLEEP);
        rise_latency(lat);
        chk("R2 sleep at timeout", lat, 2 + WAKEM + POR);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule